// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps the time of day and the calendar date as BCD register fields. A one-cycle tick input, pulsed 64 times per second, drives a prescaler that advances the seconds counter once every 64 ticks. From the seconds counter, carries ripple through minutes, hours, day of month, weekday, month and year. Month lengths follow the calendar, and February gains a 29th day in leap years. When the year wraps from 99 to 00, a century bit beside the month field toggles.

Software reaches every field through a single-cycle write port and a combinational read port, both indexed by a 4-bit register address. Four alarm registers hold a minute, hour, day and weekday. Each has its own disable bit. The block compares the enabled alarm fields against the time and raises a sticky alarm flag when the time advances into a matching state. A sticky voltage-low bit records any assertion of an external comparator input. A halt bit in the control register freezes the time and parks the prescaler at zero.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count 00..59 and hours count 00..23 in BCD. Each field wraps to 00 and carries into the next field when it passes its maximum. Register map: 0x0 seconds (bits 6:0; bit 7 is the voltage-low bit), 0x1 minutes, 0x2 hours, 0x3 day, 0x4 weekday, 0x5 month (bits 4:0; bit 7 is the century bit), 0x6 year.
- R2: The day counts from 01. April, June, September and November end after day 30. Every other month except February ends after day 31. At the end of a month the day returns to 01 and the month advances; after month 12 it returns to 01.
- R3: February ends after day 29 when the BCD year is a multiple of 4, year 00 included, and after day 28 otherwise.
- R4: The year counts 00..99 in BCD. The century bit (bit 7 of register 0x5) toggles exactly when the year wraps from 99 to 00.
- R5: The binary weekday (0..6) advances by one whenever the day advances, and goes from 6 back to 0.
- R6: After reset, or after the halt bit has been set and then cleared, the first seconds increment happens on the 32nd tick. Each later increment happens 64 ticks after the previous one.
- R7: While the halt bit (bit 0 of control register 0xB) is 1, no time field changes on ticks and the prescaler is held at zero.
- R8: Alarm registers 0x7 (minute), 0x8 (hour), 0x9 (day) and 0xA (weekday) take part in the comparison only when their bit 7 is 0. A field with bit 7 set to 1 is ignored.
- R9: The alarm flag (bit 1 of register 0xB, also on port alarm_flag) is set when a seconds increment moves the time from a state where the enabled alarm fields do not all match into one where they do. The flag stays set until a write to 0xB with bit 1 = 0. A write with bit 1 = 1 leaves it unchanged.
- R10: Once the flag is cleared, later increments that stay inside the same matching state do not set it again.
- R11: The voltage-low bit (bit 7 of register 0x0) is set on any cycle where lowv_in is 1. It stays set until a write to 0x0 with bit 7 = 0.
- R12: On reset all time fields read 0, the voltage-low bit reads 1, each alarm register reads 0x80, and the control register reads 0x00.
- R13: Unimplemented bits read 0. The hours and day registers keep bits 5:0. Weekday keeps bits 2:0. The month register keeps bits 7 and 4:0. The hour and day alarms keep bits 7 and 5:0. The weekday alarm keeps bits 7 and 2:0. Addresses 0xC..0xF read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_64 | input | 1 | One-cycle pulse, 64 per second |
| lowv_in | input | 1 | Supply-low comparator output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 8 | Read data (combinational) |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The hardest states to reach from the ports are the rare carry chains: month-end in each length class, leap and non-leap February, and the year-99 wrap that toggles the century bit. Reaching them by ticking in real time would take months of simulated ticks. The bench writes a starting time one second before each boundary, then pulses the halt bit so the prescaler restarts at half phase, and applies exactly 32 ticks to produce a single increment. The alarm edge rule is reached the same way. The bench steps the time into, through and out of a matching minute, clearing the flag in between.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int NUM_ALM = 4;
    localparam int AF_BIT  = 1;
    localparam int HALT_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC   = 4'h0,
        A_MIN   = 4'h1,
        A_HR    = 4'h2,
        A_DAY   = 4'h3,
        A_WDAY  = 4'h4,
        A_MON   = 4'h5,
        A_YR    = 4'h6,
        A_AMIN  = 4'h7,
        A_AHR   = 4'h8,
        A_ADAY  = 4'h9,
        A_AWDAY = 4'hA,
        A_CTRL  = 4'hB
    } rtcc_addr_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hr;
        logic [5:0] day;
        logic [2:0] wday;
        logic       cent;
        logic [4:0] mon;
        logic [7:0] yr;
    } rtc_time_t;

    typedef logic [NUM_ALM-1:0][6:0] alm_fields_t;

    // add one to a two-digit BCD value (caller handles the wrap)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        else                return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // BCD year divisible by four: even tens need units 0/4/8, odd tens need 2/6
    function automatic logic bcd_div4(input logic [7:0] y);
        if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
        else       return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    endfunction

    function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return bcd_div4(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    // fields compared by the alarm, index = alarm register order
    function automatic alm_fields_t alarm_fields(input rtc_time_t t);
        alm_fields_t f;
        f[0] = t.min;
        f[1] = {1'b0, t.hr};
        f[2] = {1'b0, t.day};
        f[3] = {4'b0, t.wday};
        return f;
    endfunction

    // implemented bits of each alarm register
    function automatic logic [DATA_W-1:0] alarm_mask(input int idx);
        case (idx)
            0:       return 8'hFF;
            1, 2:    return 8'hBF;
            default: return 8'h87;
        endcase
    endfunction

endpackage

// File: rtl/rtcc_prescaler.sv
module rtcc_prescaler #(
    parameter int PRE_BITS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic halt,
    output logic step
);
    localparam logic [PRE_BITS-1:0] STEP_AT = PRE_BITS'((1 << (PRE_BITS - 1)) - 1);

    logic [PRE_BITS-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || halt) cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    // firing at mid-count gives half a period after a restart, full periods after
    assign step = tick && !halt && (cnt_q == STEP_AT);
endmodule

// File: rtl/rtcc_time_chain.sv
module rtcc_time_chain
    import rtcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output rtc_time_t         cur,
    output alm_fields_t       nxt_fields
);
    rtc_time_t nxt;
    logic sec_c, min_c, hr_c, day_c, mon_c, yr_c;

    always_comb begin
        nxt   = cur;
        sec_c = (cur.sec == 7'h59);
        min_c = sec_c && (cur.min == 7'h59);
        hr_c  = min_c && (cur.hr == 6'h23);
        day_c = hr_c && (cur.day >= last_day(cur.mon, cur.yr));
        mon_c = day_c && (cur.mon >= 5'h12);
        yr_c  = mon_c && (cur.yr == 8'h99);

        nxt.sec = sec_c ? 7'h00 : 7'(bcd_inc({1'b0, cur.sec}));
        if (sec_c) nxt.min = min_c ? 7'h00 : 7'(bcd_inc({1'b0, cur.min}));
        if (min_c) nxt.hr  = hr_c  ? 6'h00 : 6'(bcd_inc({2'b0, cur.hr}));
        if (hr_c) begin
            nxt.day  = day_c ? 6'h01 : 6'(bcd_inc({2'b0, cur.day}));
            nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
        end
        if (day_c) nxt.mon = mon_c ? 5'h01 : 5'(bcd_inc({3'b0, cur.mon}));
        if (mon_c) nxt.yr  = yr_c ? 8'h00 : bcd_inc(cur.yr);
        nxt.cent = cur.cent ^ yr_c;
    end

    assign nxt_fields = alarm_fields(nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            if (step) cur <= nxt;
            if (wr_en) begin
                case (rtcc_addr_e'(wr_addr))
                    A_SEC:  cur.sec  <= wr_data[6:0];
                    A_MIN:  cur.min  <= wr_data[6:0];
                    A_HR:   cur.hr   <= wr_data[5:0];
                    A_DAY:  cur.day  <= wr_data[5:0];
                    A_WDAY: cur.wday <= wr_data[2:0];
                    A_MON: begin
                        cur.cent <= wr_data[7];
                        cur.mon  <= wr_data[4:0];
                    end
                    A_YR:   cur.yr   <= wr_data;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtcc_alarm.sv
module rtcc_alarm
    import rtcc_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            step,
    input  alm_fields_t                     cur_fields,
    input  alm_fields_t                     nxt_fields,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [NUM_ALM-1:0][DATA_W-1:0]  alm_q,
    output logic                            af
);
    logic [NUM_ALM-1:0] hit_now, hit_nxt;

    for (genvar g = 0; g < NUM_ALM; g++) begin : g_field
        localparam logic [DATA_W-1:0] MASK = alarm_mask(g);
        localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(A_AMIN) + ADDR_W'(g);

        always_ff @(posedge clk) begin
            if (rst)                              alm_q[g] <= 8'h80;
            else if (wr_en && (wr_addr == ADDR))  alm_q[g] <= wr_data & MASK;
        end

        // bit 7 set disables the field, which then always counts as a hit
        assign hit_now[g] = alm_q[g][7] || (alm_q[g][6:0] == cur_fields[g]);
        assign hit_nxt[g] = alm_q[g][7] || (alm_q[g][6:0] == nxt_fields[g]);
    end

    logic enter_match;
    assign enter_match = step && (&hit_nxt) && !(&hit_now);

    always_ff @(posedge clk) begin
        if (rst)
            af <= 1'b0;
        else if (enter_match)
            af <= 1'b1;
        else if (wr_en && (wr_addr == ADDR_W'(A_CTRL)) && !wr_data[AF_BIT])
            af <= 1'b0;
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtcc_pkg::*;
#(
    parameter int PRE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_64,
    input  logic              lowv_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              alarm_flag
);
    rtc_time_t                      cur_time;
    alm_fields_t                    nxt_fields;
    logic [NUM_ALM-1:0][DATA_W-1:0] alm_q;
    logic                           sec_step;
    logic                           stop_q;
    logic                           vl_q;
    logic                           af;

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b0;
            vl_q   <= 1'b1;
        end else begin
            if (wr_en && (wr_addr == ADDR_W'(A_CTRL))) stop_q <= wr_data[HALT_BIT];
            if (lowv_in)
                vl_q <= 1'b1;
            else if (wr_en && (wr_addr == ADDR_W'(A_SEC)))
                vl_q <= wr_data[7];
        end
    end

    rtcc_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_64),
        .halt (stop_q),
        .step (sec_step)
    );

    rtcc_time_chain u_chain (
        .clk        (clk),
        .rst        (rst),
        .step       (sec_step),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cur        (cur_time),
        .nxt_fields (nxt_fields)
    );

    rtcc_alarm u_alarm (
        .clk        (clk),
        .rst        (rst),
        .step       (sec_step),
        .cur_fields (alarm_fields(cur_time)),
        .nxt_fields (nxt_fields),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .alm_q      (alm_q),
        .af         (af)
    );

    always_comb begin
        case (rtcc_addr_e'(rd_addr))
            A_SEC:   rd_data = {vl_q, cur_time.sec};
            A_MIN:   rd_data = {1'b0, cur_time.min};
            A_HR:    rd_data = {2'b0, cur_time.hr};
            A_DAY:   rd_data = {2'b0, cur_time.day};
            A_WDAY:  rd_data = {5'b0, cur_time.wday};
            A_MON:   rd_data = {cur_time.cent, 2'b0, cur_time.mon};
            A_YR:    rd_data = cur_time.yr;
            A_AMIN:  rd_data = alm_q[0];
            A_AHR:   rd_data = alm_q[1];
            A_ADAY:  rd_data = alm_q[2];
            A_AWDAY: rd_data = alm_q[3];
            A_CTRL:  rd_data = {6'b0, af, stop_q};
            default: rd_data = '0;
        endcase
    end

    assign alarm_flag = af;
endmodule

// File: rtl/rtcc_checker.sv
module rtcc_checker
    import rtcc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_keep_af,
    input logic              lowv_in,
    input logic              sec_step,
    input logic              stop_q,
    input logic              vl_q,
    input logic              af,
    input rtc_time_t         cur_time
);
    // R7: with no increment and no write the time is frozen
    p_time_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!sec_step && !wr_en) |=> $stable(cur_time));

    // R7: a halted prescaler never produces an increment
    p_halt_no_step_r7: assert property (@(posedge clk) disable iff (rst)
        stop_q |-> !sec_step);

    // R1: seconds wrap to zero after 59
    p_sec_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (sec_step && !wr_en && cur_time.sec == 7'h59) |=> (cur_time.sec == 7'h00));

    // R4: century bit toggles on the last second of year 99
    p_cent_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (sec_step && !wr_en && cur_time.yr == 8'h99 && cur_time.mon == 5'h12 &&
         cur_time.day == 6'h31 && cur_time.hr == 6'h23 && cur_time.min == 7'h59 &&
         cur_time.sec == 7'h59) |=> (cur_time.cent != $past(cur_time.cent)));

    // R9: the flag holds unless a clearing control write arrives
    p_af_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (af && !(wr_en && wr_addr == ADDR_W'(A_CTRL) && !wr_keep_af)) |=> af);

    // R10: the flag only rises on an increment
    p_af_on_step_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(af) |-> $past(sec_step));

    // R11: the low-voltage input sets the bit
    p_vl_set_r11: assert property (@(posedge clk) disable iff (rst)
        lowv_in |=> vl_q);
endmodule

bind rtc_calendar_core rtcc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_keep_af (wr_data[1]),
    .lowv_in    (lowv_in),
    .sec_step   (sec_step),
    .stop_q     (stop_q),
    .vl_q       (vl_q),
    .af         (af),
    .cur_time   (cur_time)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
    localparam logic [3:0] R_SEC = 4'h0, R_MIN = 4'h1, R_HR = 4'h2, R_DAY = 4'h3,
                           R_WD = 4'h4, R_MON = 4'h5, R_YR = 4'h6, R_AMIN = 4'h7,
                           R_AHR = 4'h8, R_ADAY = 4'h9, R_AWD = 4'hA, R_CTRL = 4'hB;

    logic clk = 1'b0, rst = 1'b1, tick_64 = 1'b0, lowv_in = 1'b0, wr_en = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       alarm_flag;

    int checks = 0, failures = 0, cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_calendar_core u_dut (
        .clk(clk), .rst(rst), .tick_64(tick_64), .lowv_in(lowv_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .alarm_flag(alarm_flag)
    );

    // {start sec,min,hr,day,wd,mon,yr, expected sec,min,hr,day,wd,mon,yr}
    localparam int NV = 14;
    localparam logic [111:0] VEC [NV] = '{
        {56'h05_00_00_01_00_01_00, 56'h06_00_00_01_00_01_00}, // R1 seconds
        {56'h59_12_07_10_02_03_25, 56'h00_13_07_10_02_03_25}, // R1 minute carry
        {56'h59_59_09_10_02_03_25, 56'h00_00_10_10_02_03_25}, // R1 hour BCD carry
        {56'h59_59_23_15_03_06_24, 56'h00_00_00_16_04_06_24}, // R5 midnight
        {56'h59_59_23_30_06_04_24, 56'h00_00_00_01_00_05_24}, // R2 30-day, R5 wrap
        {56'h59_59_23_30_01_05_24, 56'h00_00_00_31_02_05_24}, // R2 31-day month
        {56'h59_59_23_31_04_01_10, 56'h00_00_00_01_05_02_10}, // R2 January end
        {56'h59_59_23_28_01_02_24, 56'h00_00_00_29_02_02_24}, // R3 leap 24
        {56'h59_59_23_28_01_02_23, 56'h00_00_00_01_02_03_23}, // R3 non-leap
        {56'h59_59_23_28_05_02_00, 56'h00_00_00_29_06_02_00}, // R3 year 00
        {56'h59_59_23_29_03_02_00, 56'h00_00_00_01_04_03_00}, // R3 Feb 29 end
        {56'h59_59_23_28_05_02_12, 56'h00_00_00_29_06_02_12}, // R3 odd tens
        {56'h59_59_23_31_06_12_99, 56'h00_00_00_01_00_81_00}, // R4 century 0->1
        {56'h59_59_23_31_02_92_99, 56'h00_00_00_01_03_01_00}  // R4 century 1->0
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_64 = 1'b1;
            @(negedge clk); tick_64 = 1'b0;
        end
    endtask

    // halt pulse restarts the prescaler; 32 ticks then give one increment
    task automatic one_inc();
        wr(R_CTRL, 8'h03);
        wr(R_CTRL, 8'h02);
        ticks(32);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(R_HR, h); wr(R_MIN, m); wr(R_SEC, s);
    endtask

    logic [7:0] d, d2;
    logic [55:0] got;

    initial begin
        do_reset();

        // R12 reset state
        rd(R_SEC, d);  chk("R12 seconds/low-voltage", d, 8'h80);
        got = '0;
        for (int a = 1; a <= 6; a++) begin rd(4'(a), d); got = {got[47:0], d}; end
        chk("R12 time fields", got, 56'h0);
        got = '0;
        for (int a = 7; a <= 10; a++) begin rd(4'(a), d); got = {got[47:0], d}; end
        chk("R12 alarm regs", got, 56'h80808080);
        rd(R_CTRL, d); chk("R12 control", d, 8'h00);
        chk("R12 alarm_flag", alarm_flag, 1'b0);

        // R13 implemented bits
        wr(R_HR, 8'hFF);  rd(R_HR, d);  chk("R13 hours mask", d, 8'h3F);
        wr(R_WD, 8'hFF);  rd(R_WD, d);  chk("R13 weekday mask", d, 8'h07);
        wr(R_MON, 8'hFF); rd(R_MON, d); chk("R13 month mask", d, 8'h9F);
        wr(R_AHR, 8'hFF); rd(R_AHR, d); chk("R13 hour alarm mask", d, 8'hBF);
        wr(R_AWD, 8'hFF); rd(R_AWD, d); chk("R13 weekday alarm mask", d, 8'h87);
        rd(4'hD, d); chk("R13 unused address", d, 8'h00);

        // R6 prescaler phase from reset
        do_reset();
        ticks(31); rd(R_SEC, d); chk("R6 no step before tick 32", d, 8'h80);
        ticks(1);  rd(R_SEC, d); chk("R6 step at tick 32", d, 8'h81);
        ticks(63); rd(R_SEC, d); chk("R6 no step before 64 more", d, 8'h81);
        ticks(1);  rd(R_SEC, d); chk("R6 step after 64 more", d, 8'h82);
        // R6 restart after halt
        ticks(20);
        wr(R_CTRL, 8'h01); wr(R_CTRL, 8'h00);
        ticks(31); rd(R_SEC, d); chk("R6 halt restart holds 31", d, 8'h82);
        ticks(1);  rd(R_SEC, d); chk("R6 halt restart step at 32", d, 8'h83);

        // R1 R2 R3 R4 R5 calendar vectors
        for (int v = 0; v < NV; v++) begin
            wr(R_SEC, VEC[v][111:104]); wr(R_MIN, VEC[v][103:96]);
            wr(R_HR,  VEC[v][95:88]);   wr(R_DAY, VEC[v][87:80]);
            wr(R_WD,  VEC[v][79:72]);   wr(R_MON, VEC[v][71:64]);
            wr(R_YR,  VEC[v][63:56]);
            one_inc();
            got = '0;
            for (int a = 0; a <= 6; a++) begin rd(4'(a), d); got = {got[47:0], d}; end
            chk($sformatf("R1 R2 R3 R4 R5 vector %0d", v), got, VEC[v][55:0]);
        end

        // R7 halt freezes time
        rd(R_SEC, d2);
        wr(R_CTRL, 8'h01);
        ticks(100);
        rd(R_SEC, d); chk("R7 seconds frozen while halted", d, d2);
        rd(R_CTRL, d); chk("R7 halt bit readback", d, 8'h01);
        wr(R_CTRL, 8'h00);

        // R8 R9 R10 alarm
        wr(R_AMIN, 8'h30); wr(R_AHR, 8'h80); wr(R_ADAY, 8'h80); wr(R_AWD, 8'h80);
        wr(R_CTRL, 8'h00);
        set_hms(8'h10, 8'h29, 8'h58);
        one_inc(); chk("R9 no flag before match", alarm_flag, 1'b0);
        one_inc(); chk("R9 flag on entering match", alarm_flag, 1'b1);
        rd(R_CTRL, d); chk("R9 flag in control bit 1", d, 8'h02);
        wr(R_CTRL, 8'h02); chk("R9 write 1 keeps flag", alarm_flag, 1'b1);
        wr(R_CTRL, 8'h00); chk("R9 write 0 clears flag", alarm_flag, 1'b0);
        one_inc(); chk("R10 persisting match no reset", alarm_flag, 1'b0);
        wr(R_CTRL, 8'h02); chk("R9 write 1 on clear flag", alarm_flag, 1'b0);
        wr(R_AHR, 8'h11);
        set_hms(8'h10, 8'h29, 8'h59);
        one_inc(); chk("R8 enabled hour mismatch", alarm_flag, 1'b0);
        set_hms(8'h11, 8'h29, 8'h59);
        one_inc(); chk("R8 minute and hour match", alarm_flag, 1'b1);
        wr(R_CTRL, 8'h00);
        wr(R_AHR, 8'h91);
        set_hms(8'h10, 8'h29, 8'h59);
        one_inc(); chk("R8 disabled hour ignored", alarm_flag, 1'b1);

        // R11 low-voltage bit
        wr(R_SEC, 8'h00); rd(R_SEC, d); chk("R11 cleared by write", d[7], 1'b0);
        @(negedge clk); lowv_in = 1'b1;
        @(negedge clk); lowv_in = 1'b0;
        repeat (5) @(negedge clk);
        rd(R_SEC, d); chk("R11 set by input and sticky", d[7], 1'b1);
        wr(R_SEC, 8'h00); rd(R_SEC, d); chk("R11 clear again", d, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule